// File: doc/BRIEF.md
# Bidirectional Read/Write Buffer with Write Queue

This block sits between a fast processor-side port A and a slower memory or peripheral port B, both 18 bits wide and bidirectional. Traffic from A toward B passes through a four-entry first-in first-out queue. One clock runs the queue. Two active-low enables control it: one stores a word taken from port A, and the other moves the oldest stored word into a registered output that drives port B. An active-low flag reports when the queue is full. A synchronous active-low reset empties the queue and sets its output to all ones.

Traffic from B toward A passes through a level-sensitive latch. While the latch enable is high, port B data appears on port A. When the enable falls, the latch keeps the value it holds. Each port has its own active-low output enable. When its enable is inactive, a port is released to high impedance so that the other side can drive it.

The queue and the latch are independent. A processor can post several writes and then read back a word from memory without waiting for the posted writes to drain.

Top module: `bidir_rw_buffer`

## Requirements
- R1: When the write enable is low on a rising edge and the queue is not full, the word on port A is stored. When the read enable is low and the queue is not empty, the oldest stored word becomes the queue output. Words leave in the order they were stored.
- R2: `full_n` is low exactly while four words are stored. It is high in the cycle after a reset edge.
- R3: A write attempted while four words are stored, with no read in the same cycle, changes neither the stored words nor the queue output.
- R4: A read attempted while the queue is empty, with no write in the same cycle, leaves the queue output at the last word read.
- R5: A low `rst_n` on a rising edge empties the queue and sets the queue output to all ones (0x3FFFF). Reset wins over both enables in the same cycle.
- R6: When a read and a write occur together with one to three words stored, both take effect. With exactly one word stored, that word is output and the new word becomes the only entry.
- R7: When a read and a write occur together on an empty queue, the write is stored and the read is dropped, so the output does not change.
- R8: When a read and a write occur together on a full queue, the read is performed and the write is dropped, leaving three words.
- R9: The queue output changes only on a successful read or on reset. A write alone never changes it.
- R10: While `latch_en` is high, port A follows port B with no clock involved. After `latch_en` falls, port A keeps the value that was present at the fall.
- R11: Port B carries the queue output while `oe_b_n` is low and is released (high impedance) while it is high. Port A carries the latch value while `oe_a_n` is low and is released while it is high.
- R12: Operations on the queue do not disturb the value held in the latch, and the latch enable has no effect on the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the write queue |
| rst_n | input | 1 | Synchronous active-low queue reset |
| wr_en_n | input | 1 | Active-low enable that stores port A data |
| rd_en_n | input | 1 | Active-low enable that advances the queue output |
| full_n | output | 1 | Low while the queue holds four words |
| oe_b_n | input | 1 | Active-low enable for the port B drivers |
| oe_a_n | input | 1 | Active-low enable for the port A drivers |
| latch_en | input | 1 | High: B-to-A latch transparent; low: latch holds |
| port_a | inout | 18 | Processor-side data |
| port_b | inout | 18 | Memory-side data |

## Verification
Every queue result, whether the output word, the full flag or the effect of a reset, is due one rising edge after the enables are sampled. No register sits between that edge and the pins. The bench therefore applies inputs on a falling edge, lets one rising edge pass, and compares port B and `full_n` with its queue model on the next falling edge. Latch results do not depend on the clock. They are checked one nanosecond after `latch_en` or port B changes, and again after queue activity, to show that the held value persists.

// File: rtl/rwb_pkg.sv
package rwb_pkg;
    localparam int DEF_DATA_W = 18;
    localparam int DEF_DEPTH  = 4;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_BOTH = 2'd3
    } fifo_op_e;
endpackage

// File: rtl/rwb_wr_fifo.sv
module rwb_wr_fifo
    import rwb_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int DEPTH  = DEF_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_n,
    input  logic              rd_en_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              full_n
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
    localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PW-1:0]                wptr;
        logic [PW-1:0]                rptr;
        logic [CW-1:0]                cnt;
        logic [DATA_W-1:0]            dout;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    fifo_op_e op;
    logic     push_ok, pop_ok;

    always_comb begin
        push_ok = !wr_en_n && (st_q.cnt != CNT_FULL);
        pop_ok  = !rd_en_n && (st_q.cnt != '0);
        op      = fifo_op_e'({pop_ok, push_ok});
        st_d    = st_q;
        if (!rst_n) begin
            st_d.wptr = '0;
            st_d.rptr = '0;
            st_d.cnt  = '0;
            st_d.dout = '1;
        end else begin
            if (push_ok) begin
                st_d.mem[st_q.wptr] = din;
                st_d.wptr = (st_q.wptr == PTR_LAST) ? '0 : st_q.wptr + 1'b1;
            end
            if (pop_ok) begin
                st_d.dout = st_q.mem[st_q.rptr];
                st_d.rptr = (st_q.rptr == PTR_LAST) ? '0 : st_q.rptr + 1'b1;
            end
            case (op)
                OP_PUSH: st_d.cnt = st_q.cnt + 1'b1;
                OP_POP:  st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dout   = st_q.dout;
    assign full_n = (st_q.cnt != CNT_FULL);

    assert_full_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && !wr_en_n && rd_en_n) |=> (!full_n && $stable(dout)));

    assert_empty_read_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '0 && !rd_en_n && wr_en_n) |=> $stable(dout));

    assert_reset_state_R5: assert property (@(posedge clk)
        (!rst_n) |=> (dout == '1 && full_n));

    assert_full_rdwr_drops_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && !wr_en_n && !rd_en_n) |=> full_n);

    assert_output_only_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_n) |=> $stable(dout));
endmodule

// File: rtl/rwb_rd_latch.sv
module rwb_rd_latch #(
    parameter int DATA_W = rwb_pkg::DEF_DATA_W
) (
    input  logic              le,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);
    always_latch begin
        if (le) q = d;
    end
endmodule

// File: rtl/bidir_rw_buffer.sv
module bidir_rw_buffer
    import rwb_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int DEPTH  = DEF_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_n,
    input  logic              rd_en_n,
    output logic              full_n,
    input  logic              oe_b_n,
    input  logic              oe_a_n,
    input  logic              latch_en,
    inout  wire  [DATA_W-1:0] port_a,
    inout  wire  [DATA_W-1:0] port_b
);
    logic [DATA_W-1:0] fifo_out;
    logic [DATA_W-1:0] latch_q;

    rwb_wr_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_n (wr_en_n),
        .rd_en_n (rd_en_n),
        .din     (port_a),
        .dout    (fifo_out),
        .full_n  (full_n)
    );

    rwb_rd_latch #(.DATA_W(DATA_W)) u_latch (
        .le (latch_en),
        .d  (port_b),
        .q  (latch_q)
    );

    assign port_b = oe_b_n ? {DATA_W{1'bz}} : fifo_out;
    assign port_a = oe_a_n ? {DATA_W{1'bz}} : latch_q;

    assert_latch_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_en && $past(!latch_en)) |-> $stable(latch_q));

    assert_fifo_ignores_latch_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_n) |=> $stable(fifo_out));
endmodule

// File: tb/sim_bidir_rw_buffer.sv
`timescale 1ns/1ps
module sim_bidir_rw_buffer;
    localparam int W = 18;
    localparam int D = 4;

    logic clk = 1'b0;
    logic rst_n, wr_en_n, rd_en_n, oe_b_n, oe_a_n, latch_en;
    logic full_n;
    logic         drv_a, drv_b;
    logic [W-1:0] tb_a, tb_b;
    wire  [W-1:0] port_a, port_b;

    assign port_a = drv_a ? tb_a : {W{1'bz}};
    assign port_b = drv_b ? tb_b : {W{1'bz}};

    int n_cmp = 0;
    int n_bad = 0;
    logic [W-1:0] q[$];
    logic [W-1:0] m_out;
    logic [W-1:0] held;

    always #2.5 clk = ~clk;

    bidir_rw_buffer u0 (
        .clk(clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .rd_en_n(rd_en_n),
        .full_n(full_n), .oe_b_n(oe_b_n), .oe_a_n(oe_a_n), .latch_en(latch_en),
        .port_a(port_a), .port_b(port_b)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // One clock: drive at falling edge, model at rising edge, compare at next falling edge.
    task automatic step(input string req, input logic rst, input logic wr, input logic rd,
                        input logic [W-1:0] a);
        bit can_push, can_pop;
        rst_n = rst; wr_en_n = wr; rd_en_n = rd; tb_a = a;
        @(posedge clk);
        if (!rst) begin
            q.delete();
            m_out = '1;
        end else begin
            can_push = !wr && q.size() < D;
            can_pop  = !rd && q.size() > 0;
            if (can_pop)  m_out = q.pop_front();
            if (can_push) q.push_back(a);
        end
        @(negedge clk);
        rst_n = 1'b1; wr_en_n = 1'b1; rd_en_n = 1'b1;
        if (!oe_b_n) check({req, " qout"}, port_b, m_out);
        check({req, " full_n"}, {{(W-1){1'b0}}, full_n}, {{(W-1){1'b0}}, (q.size() != D)});
    endtask

    initial begin
        #(200000 * 5);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; wr_en_n = 1'b1; rd_en_n = 1'b1;
        oe_b_n = 1'b0; oe_a_n = 1'b1; latch_en = 1'b0;
        drv_a = 1'b1; drv_b = 1'b0; tb_a = '0; tb_b = '0;
        m_out = '1;
        @(negedge clk);
        step("R5 reset", 1'b0, 1'b1, 1'b1, '0);
        step("R5 reset", 1'b0, 1'b1, 1'b1, '0);
        check("R2 full_n after reset", {17'd0, full_n}, 18'd1);
        // fill, with output unchanged by writes alone
        for (int i = 0; i < 4; i++) step("R1 R9 write", 1'b1, 1'b0, 1'b1, 18'h100 + 18'(i));
        check("R2 full at four", {17'd0, full_n}, 18'd0);
        step("R3 write to full", 1'b1, 1'b0, 1'b1, 18'h3AAAA);
        for (int i = 0; i < 4; i++) step("R1 read order", 1'b1, 1'b1, 1'b0, '0);
        check("R1 last word", port_b, 18'h103);
        step("R4 read empty", 1'b1, 1'b1, 1'b0, '0);
        step("R7 rdwr on empty", 1'b1, 1'b0, 1'b0, 18'h00555);
        step("R6 rdwr at one", 1'b1, 1'b0, 1'b0, 18'h00666);
        check("R6 word out", port_b, 18'h00555);
        step("R6 rdwr at one again", 1'b1, 1'b0, 1'b0, 18'h00777);
        for (int i = 0; i < 3; i++) step("R1 refill", 1'b1, 1'b0, 1'b1, 18'h200 + 18'(i));
        step("R8 rdwr on full", 1'b1, 1'b0, 1'b0, 18'h3BBBB);
        step("R6 rdwr at three", 1'b1, 1'b0, 1'b0, 18'h00888);
        for (int i = 0; i < 4; i++) step("R1 drain", 1'b1, 1'b1, 1'b0, '0);
        step("R4 read empty hold", 1'b1, 1'b1, 1'b0, '0);
        step("R1 write", 1'b1, 1'b0, 1'b1, 18'h01234);
        step("R5 reset priority", 1'b0, 1'b0, 1'b0, 18'h04321);
        step("R5 empty after reset", 1'b1, 1'b1, 1'b0, '0);

        // latch path: B driven by bench, A driven by design
        oe_b_n = 1'b1; drv_b = 1'b1; drv_a = 1'b0; oe_a_n = 1'b0;
        tb_b = 18'h0ABCD; #1;
        check("R11 B released to bench", port_b, 18'h0ABCD);
        latch_en = 1'b1; #1;
        check("R10 R11 transparent", port_a, 18'h0ABCD);
        tb_b = 18'h13579; #1;
        check("R10 follows B", port_a, 18'h13579);
        latch_en = 1'b0; #1;
        tb_b = 18'h2468A; #1;
        check("R10 holds after fall", port_a, 18'h13579);
        held = 18'h13579;
        @(negedge clk);
        // queue activity while latch holds; A is driven by design so write data is latch value
        drv_a = 1'b0;
        step("R12 write while holding", 1'b1, 1'b0, 1'b1, held);
        check("R12 latch unchanged", port_a, held);
        oe_b_n = 1'b0; drv_b = 1'b0;
        step("R12 read while holding", 1'b1, 1'b1, 1'b0, held);
        check("R12 latch unchanged", port_a, held);
        check("R12 queue word", port_b, held);
        oe_a_n = 1'b1; drv_a = 1'b1; tb_a = 18'h0F0F0; #1;
        check("R11 A released to bench", port_a, 18'h0F0F0);
        finish_run();
    end
endmodule